// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block gathers interrupt requests from the switch's internal engines and from thirteen MAC ports into one 32-bit status word. The word drives a single registered interrupt line to the host CPU. The CPU reaches the block through a simple word-wide bus with select, write and ready signals. Four registers are visible on that bus: raw status, masked status, mask and acknowledge.

Most sources are single-cycle event pulses. Each one is latched and stays pending until the CPU writes a one to its bit in the acknowledge register. Two sources, the CPU output queue and mail arrival, are level conditions. Each follows its queue-occupancy input and cannot be cleared by software. A mask bit of 1 disables its source. The masked-status register and the interrupt line see only pending sources that are not masked.

Status reads finish in the cycle they are issued. Mask and acknowledge accesses always take one wait state.

Top module: `irq_collector`

## Requirements
- R1: Byte addresses decode as follows: 0x7E0 raw status (read only), 0x7E4 masked status (read only), 0x7E8 mask (read/write) and 0x7EC acknowledge (write only). A read of the acknowledge register or of any other address returns zero.
- R2: An event pulse on `ev_in` at a latched bit sets that status bit, and it stays set until acknowledged. The latched bits are 1, 2, 3, 4, 8, 10, 11 through 23 (MAC port n at bit 11+n) and 24.
- R3: Writing the acknowledge register clears every latched status bit written as 1. Bits written as 0 keep their value.
- R4: If an event pulse and an acknowledge of the same bit meet in one cycle, the bit stays set.
- R5: Status bit 0 equals `cpuq_lvl` and status bit 7 equals `mail_lvl` at all times. Acknowledge writes have no effect on them.
- R6: Masked status equals raw status AND NOT mask. A mask write stores the written value for implemented bits, and the mask reads back that value.
- R7: `irq` is 1 exactly when the masked status of the previous cycle is nonzero.
- R8: After reset all status bits are 0 and `irq` is 0. The mask reads 0x01FFFD9F, meaning every implemented source is disabled.
- R9: Reads of the two status registers and accesses to unmapped addresses raise `bus_ready` in their first cycle. Mask and acknowledge accesses raise it in their second cycle.
- R10: Writes to the status registers or to unmapped addresses change no register.
- R11: Bits 5, 6, 9 and 25 through 31 read as zero in every register, and event pulses on them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_in | input | 32 | Single-cycle event pulses, one per status bit |
| cpuq_lvl | input | 1 | CPU output queue not empty |
| mail_lvl | input | 1 | Mail queue not empty |
| bus_sel | input | 1 | Access request, held until ready |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while ready |
| bus_ready | output | 1 | Access completes at this clock edge |
| irq | output | 1 | Registered interrupt to the CPU |

## Verification
The first directed patterns are a lone pulse, a pulse that meets an acknowledge of the same bit, and an acknowledge of a level bit. Together they separate the latched, set-wins and level-following paths. Mask patterns of all zeros, all ones and alternating bits show whether masked status and `irq` use the mask with the right polarity. A seeded random mix of pulses, mask writes, acknowledges, level toggles and reads of every address follows. Each read is compared with a bench model, and so is the wait count of every access. This exposes decode, wait-state and clear-versus-set faults that only appear when operations interleave.

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter int AW = 12,
  parameter logic [AW-1:0] BASE = 12'h7E0,
  parameter logic [31:0] LATCHED = 32'h01FF_FD1E,
  parameter int CPUQ_BIT = 0,
  parameter int MAIL_BIT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   ev_in,
  input  logic          cpuq_lvl,
  input  logic          mail_lvl,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          bus_ready,
  output logic          irq
);
  localparam logic [31:0] LEVEL = (32'd1 << CPUQ_BIT) | (32'd1 << MAIL_BIT);
  localparam logic [31:0] IMPL  = LATCHED | LEVEL;

  logic [31:0] lat_q, mask_q, raw, masked, ack_bits;
  logic        wait_q, hit_raw, hit_msk, hit_mask, hit_ack, slow, do_wr;

  assign hit_raw  = bus_addr == BASE;
  assign hit_msk  = bus_addr == BASE + 4;
  assign hit_mask = bus_addr == BASE + 8;
  assign hit_ack  = bus_addr == BASE + 12;
  assign slow     = hit_mask | hit_ack;

  assign bus_ready = bus_sel & (~slow | wait_q);
  assign do_wr     = bus_ready & bus_wr;
  assign ack_bits  = (do_wr & hit_ack) ? bus_wdata : 32'd0;

  always_comb begin
    raw = lat_q;
    raw[CPUQ_BIT] = cpuq_lvl;
    raw[MAIL_BIT] = mail_lvl;
  end
  assign masked = raw & ~mask_q;

  always_comb begin
    bus_rdata = 32'd0;
    if (bus_ready && !bus_wr) begin
      if (hit_raw)  bus_rdata = raw;
      if (hit_msk)  bus_rdata = masked;
      if (hit_mask) bus_rdata = mask_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q  <= '0;
      mask_q <= IMPL;
      wait_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      lat_q  <= ((lat_q & ~ack_bits) | ev_in) & LATCHED;
      wait_q <= bus_sel & slow & ~bus_ready;
      irq    <= |masked;
      if (do_wr && hit_mask) mask_q <= bus_wdata & IMPL;
    end
  end

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && hit_ack) |=> ((lat_q & $past(bus_wdata & ~ev_in & LATCHED)) == 32'd0)); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lat_q & $past(ev_in & LATCHED)) == $past(ev_in & LATCHED))); // R4
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(raw & ~mask_q)))); // R7
  AST_SLOW_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && slow && !$past(bus_sel)) |-> !bus_ready); // R9
  AST_SLOW_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && slow && !bus_ready) |=> (bus_sel ? bus_ready : 1'b1)); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~IMPL) == 32'd0); // R11
  AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !slow) |=> $stable(mask_q)); // R10
endmodule

// File: tb/sim_irq_collector.sv
module sim_irq_collector;
  localparam logic [31:0] LAT  = 32'h01FF_FD1E;
  localparam logic [31:0] IMPL = 32'h01FF_FD9F;
  localparam logic [11:0] A_RAW = 12'h7E0, A_MSK = 12'h7E4, A_MASK = 12'h7E8, A_ACK = 12'h7EC;

  logic clk = 0, rst_n = 0;
  logic [31:0] ev_in = 0, bus_wdata = 0;
  logic cpuq_lvl = 0, mail_lvl = 0, bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_rdata;
  logic bus_ready, irq;

  int checks = 0, fails = 0;
  logic [31:0] m_lat = 0, m_mask = IMPL;

  irq_collector u0 (.clk, .rst_n, .ev_in, .cpuq_lvl, .mail_lvl, .bus_sel, .bus_wr,
                    .bus_addr, .bus_wdata, .bus_rdata, .bus_ready, .irq);

  always #10 clk = ~clk;

  function automatic logic [31:0] exp_raw();
    return m_lat | {24'd0, mail_lvl, 6'd0, cpuq_lvl};
  endfunction
  function automatic logic [31:0] exp_read(input logic [11:0] a);
    case (a)
      A_RAW:   return exp_raw();
      A_MSK:   return exp_raw() & ~m_mask;
      A_MASK:  return m_mask;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d,
                        input logic [31:0] ev, output logic [31:0] rd, output int waits);
    @(negedge clk);
    bus_sel = 1; bus_wr = wr; bus_addr = a; bus_wdata = d; waits = 0;
    #1;
    while (!bus_ready) begin @(negedge clk); #1; waits++; end
    ev_in = ev; rd = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0; ev_in = 0;
    if (wr && a == A_ACK) m_lat = (m_lat & ~d) | (ev & LAT);
    else m_lat = m_lat | (ev & LAT);
    if (wr && a == A_MASK) m_mask = d & IMPL;
  endtask

  task automatic rd_chk(input string r, input logic [11:0] a);
    logic [31:0] v; int w;
    access(0, a, 0, 0, v, w);
    chk(r, v, exp_read(a));
    chk("R9 read waits", w, (a == A_MASK || a == A_ACK) ? 1 : 0);
  endtask

  task automatic wr_do(input string r, input logic [11:0] a, input logic [31:0] d, input logic [31:0] ev);
    logic [31:0] v; int w;
    access(1, a, d, ev, v, w);
    chk(r, w, (a == A_MASK || a == A_ACK) ? 1 : 0);
  endtask

  task automatic pulse(input logic [31:0] ev);
    @(negedge clk); ev_in = ev;
    @(posedge clk); #1; ev_in = 0;
    m_lat = m_lat | (ev & LAT);
  endtask

  task automatic irq_chk(input string r);
    @(posedge clk); @(negedge clk);
    chk(r, irq, |(exp_raw() & ~m_mask));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk("R8 irq reset", irq, 0);
    rd_chk("R8 raw reset", A_RAW);
    rd_chk("R8 mask reset", A_MASK);
    chk("R8 mask value", m_mask, 32'h01FF_FD9F);

    wr_do("R6 mask clear", A_MASK, 32'd0, 0);
    rd_chk("R6 mask readback", A_MASK);
    pulse(32'h0000_0800);              // R2 MAC port 0
    rd_chk("R2 port0 latched", A_RAW);
    irq_chk("R7 irq on port0");
    pulse(32'h0080_0000);              // R2 MAC port 12
    rd_chk("R2 port12 latched", A_RAW);
    pulse(32'hFE00_0260);              // R11 reserved pulses ignored
    rd_chk("R11 reserved ignored", A_RAW);
    wr_do("R3 ack port0", A_ACK, 32'h0000_0800, 0);
    rd_chk("R3 only acked cleared", A_RAW);
    pulse(32'h0000_0010);
    wr_do("R4 set wins", A_ACK, 32'h0000_0010, 32'h0000_0010);
    rd_chk("R4 bit still set", A_RAW);
    cpuq_lvl = 1; mail_lvl = 1;
    wr_do("R5 ack level", A_ACK, 32'h0000_0081, 0);
    rd_chk("R5 levels survive ack", A_RAW);
    cpuq_lvl = 0;
    rd_chk("R5 cpuq follows", A_RAW);
    wr_do("R10 write raw", A_RAW, 32'hFFFF_FFFF, 0);
    wr_do("R10 write msk", A_MSK, 32'hFFFF_FFFF, 0);
    wr_do("R10 write unmapped", 12'h7F0, 32'hFFFF_FFFF, 0);
    rd_chk("R10 mask unchanged", A_MASK);
    rd_chk("R10 raw unchanged", A_RAW);
    rd_chk("R1 ack reads zero", A_ACK);
    rd_chk("R1 unmapped reads zero", 12'h7E2);
    wr_do("R6 mask all", A_MASK, 32'hFFFF_FFFF, 0);
    rd_chk("R11 mask reserved zero", A_MASK);
    rd_chk("R6 masked empty", A_MSK);
    irq_chk("R7 irq masked off");
    wr_do("R6 mask alt", A_MASK, 32'hAAAA_AAAA, 0);
    rd_chk("R6 masked alt", A_MSK);
    irq_chk("R7 irq alt");

    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 5);
      logic [11:0] a = 12'h7E0 + 12'($urandom_range(0, 4) * 4);
      case (op)
        0: pulse($urandom);
        1: wr_do("R3 rand ack", A_ACK, $urandom, ($urandom_range(0, 3) == 0) ? $urandom : 0);
        2: wr_do("R6 rand mask", A_MASK, $urandom, 0);
        3: begin cpuq_lvl = 1'($urandom); mail_lvl = 1'($urandom); end
        4: rd_chk("R1 rand read", a);
        default: irq_chk("R7 rand irq");
      endcase
    end
    rd_chk("R6 final masked", A_MSK);
    v = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule